// File: doc/BRIEF.md
# Sync-Relative Video Mode Latch

This block sits between the CPU's mode register port and the pixel pipeline of a raster video generator, and runs once per character clock (1 MHz in the target system). The CPU can write a new 2-bit display mode at any time. The block holds that value as pending. It moves the value into the active mode only at one fixed point inside horizontal sync, so a mode switch never tears a visible line. The active mode is decoded into the pixel clock divide ratio. A one-clock pulse tells downstream tables that the mode changed.

The same block also shapes the vertical sync sent to the monitor. The output pulse starts a fixed number of character clocks after the input sync rises. Its length is capped, however long the input sync stays high.

Top module: `vidmode_sync_latch`

## Requirements
- R1: While reset is asserted and right after it, the active mode reads 1, the pending mode is 1, the divider reads 2, the change pulse is low and the shaped vsync is low.
- R2: Call the first clock edge that samples hsync high after a low sample edge n. If hsync is still sampled high at edge n+4, the pending mode becomes the active mode at that edge. This happens only when the pending mode differs from the active mode.
- R3: If hsync is sampled low at or before edge n+4, the active mode does not change on that line. A low sample restarts the hsync count from zero.
- R4: The pending mode is the data of the most recent write strobe. Several writes before the latch edge leave only the last value. A write sampled at the latch edge itself is not applied on that line; it is applied on the next line.
- R5: When the pending mode equals the active mode at the latch edge, nothing changes and no change pulse is produced.
- R6: The divider output follows the active mode code: code 2 gives 1, code 1 gives 2, and codes 0 and 3 give 4. The mode output reports the stored code.
- R7: The change pulse is high for exactly the one clock after the edge at which the active mode is updated. It is never high at any other time.
- R8: If vsync is first sampled high at edge m, the shaped vsync goes high after edge m+2.
- R9: The shaped vsync is high for at most 4 clocks per input vsync pulse: after edges m+2 through m+5. It drops after any edge that samples the input vsync low.
- R10: Only one latch point exists per hsync pulse. A write made after the latch edge of a long hsync is not applied until the next hsync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync from the timing generator, active high |
| vsync_i | input | 1 | Vertical sync from the timing generator, active high |
| mode_wr_i | input | 1 | CPU mode write strobe, one clock per write |
| mode_wdata_i | input | 2 | Mode code written by the CPU |
| mode_o | output | 2 | Active display mode code |
| pix_div_o | output | 3 | Pixel clock divide ratio for the active mode |
| mode_chg_o | output | 1 | One-clock pulse when the active mode changes |
| vsync_o | output | 1 | Delayed, length-limited vertical sync for the monitor |

## Verification
Mode, divider and change pulse are all due one register stage after the edge that samples hsync high for the fifth time in a row. The shaped vsync is due after the third consecutive high sample of the input and lasts four clocks at most. The bench drives inputs on falling edges. A behavioural model counts run lengths of the sampled inputs, and its results are compared with every output 1 ns after each rising edge, when the registered outputs have settled. Directed checks run at the end of each scenario: line lengths of 4 and 5 high samples, writes at, before and after the latch edge, equal-mode writes, and short and long vsync pulses.

// File: rtl/vml_pkg.sv
package vml_pkg;
   localparam int unsigned MODE_W = 2;
   localparam int unsigned DIV_W  = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_WIDE = 2'd0,
      MODE_MID  = 2'd1,
      MODE_FINE = 2'd2,
      MODE_ALT  = 2'd3
   } vmode_e;

   function automatic logic [DIV_W-1:0] div_for(input logic [MODE_W-1:0] m);
      case (vmode_e'(m))
         MODE_FINE: div_for = DIV_W'(1);
         MODE_MID:  div_for = DIV_W'(2);
         default:   div_for = DIV_W'(4);
      endcase
   endfunction
endpackage

// File: rtl/vml_run_counter.sv
module vml_run_counter #(
   parameter int unsigned MAX = 5,
   localparam int unsigned CW = $clog2(MAX + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          level_i,
   output logic [CW-1:0] cnt_o
);
   if (MAX < 1) begin : g_bad_max
      $error("vml_run_counter: MAX must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (!level_i)          cnt_q <= '0;
      else if (cnt_q != CW'(MAX)) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/vml_mode_reg.sv
module vml_mode_reg
   import vml_pkg::*;
#(
   parameter logic [MODE_W-1:0] RESET_MODE = 2'd1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              apply_i,
   input  logic              wr_i,
   input  logic [MODE_W-1:0] wdata_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [MODE_W-1:0] pend_o,
   output logic              load_o,
   output logic              chg_o
);
   logic [MODE_W-1:0] mode_q, pend_q;
   logic              chg_q;

   assign load_o = apply_i && (pend_q != mode_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= RESET_MODE;
         pend_q <= RESET_MODE;
         chg_q  <= 1'b0;
      end else begin
         chg_q <= load_o;
         if (load_o) mode_q <= pend_q;
         if (wr_i)   pend_q <= wdata_i;
      end
   end

   assign mode_o = mode_q;
   assign pend_o = pend_q;
   assign chg_o  = chg_q;
endmodule

// File: rtl/vml_div_map.sv
module vml_div_map
   import vml_pkg::*;
#(
   parameter bit                REG_DIV    = 1'b1,
   parameter logic [MODE_W-1:0] RESET_MODE = 2'd1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [MODE_W-1:0] load_mode_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [DIV_W-1:0]  div_o
);
   if (REG_DIV) begin : g_reg
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) div_q <= div_for(RESET_MODE);
         else         div_q <= div_for(load_i ? load_mode_i : mode_i);
      end
      assign div_o = div_q;
   end else begin : g_comb
      assign div_o = div_for(mode_i);
   end
endmodule

// File: rtl/vidmode_sync_latch.sv
module vidmode_sync_latch
   import vml_pkg::*;
#(
   parameter int unsigned       LATCH_AT   = 4,
   parameter int unsigned       VS_DELAY   = 2,
   parameter int unsigned       VS_WIDTH   = 4,
   parameter logic [MODE_W-1:0] RESET_MODE = 2'd1,
   parameter bit                REG_DIV    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hsync_i,
   input  logic              vsync_i,
   input  logic              mode_wr_i,
   input  logic [MODE_W-1:0] mode_wdata_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [DIV_W-1:0]  pix_div_o,
   output logic              mode_chg_o,
   output logic              vsync_o
);
   localparam int unsigned HS_MAX = LATCH_AT + 1;
   localparam int unsigned HS_CW  = $clog2(HS_MAX + 1);
   localparam int unsigned VS_MAX = VS_DELAY + VS_WIDTH;
   localparam int unsigned VS_CW  = $clog2(VS_MAX + 1);

   if (LATCH_AT < 1) begin : g_bad_latch
      $error("vidmode_sync_latch: LATCH_AT must be at least 1");
   end
   if (VS_WIDTH < 1) begin : g_bad_width
      $error("vidmode_sync_latch: VS_WIDTH must be at least 1");
   end

   logic [HS_CW-1:0]  hs_cnt;
   logic [VS_CW-1:0]  vs_cnt;
   logic              apply, load;
   logic [MODE_W-1:0] pend, mode;
   logic              vs_q;

   vml_run_counter #(.MAX(HS_MAX)) u_hs_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .level_i(hsync_i), .cnt_o(hs_cnt)
   );

   vml_run_counter #(.MAX(VS_MAX)) u_vs_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .level_i(vsync_i), .cnt_o(vs_cnt)
   );

   assign apply = hsync_i && (hs_cnt == HS_CW'(LATCH_AT));

   vml_mode_reg #(.RESET_MODE(RESET_MODE)) u_mode (
      .clk_i(clk_i), .rst_ni(rst_ni), .apply_i(apply),
      .wr_i(mode_wr_i), .wdata_i(mode_wdata_i),
      .mode_o(mode), .pend_o(pend), .load_o(load), .chg_o(mode_chg_o)
   );

   vml_div_map #(.REG_DIV(REG_DIV), .RESET_MODE(RESET_MODE)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
      .load_mode_i(pend), .mode_i(mode), .div_o(pix_div_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vs_q <= 1'b0;
      else         vs_q <= vsync_i && (vs_cnt >= VS_CW'(VS_DELAY))
                                   && (vs_cnt <  VS_CW'(VS_MAX));
   end

   assign mode_o  = mode;
   assign vsync_o = vs_q;
endmodule

// File: rtl/vml_checker.sv
module vml_checker #(
   parameter int unsigned LATCH_AT = 4,
   parameter int unsigned VS_DELAY = 2,
   parameter int unsigned VS_WIDTH = 4
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       hsync_i,
   input logic       vsync_i,
   input logic [1:0] mode_o,
   input logic [2:0] pix_div_o,
   input logic       mode_chg_o,
   input logic       vsync_o
);
   int   hs_run, vs_in_run, vs_out_run;
   logic armed;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hs_run <= 0; vs_in_run <= 0; vs_out_run <= 0; armed <= 1'b0;
      end else begin
         armed      <= 1'b1;
         hs_run     <= hsync_i ? ((hs_run < 1000) ? hs_run + 1 : hs_run) : 0;
         vs_in_run  <= vsync_i ? ((vs_in_run < 1000) ? vs_in_run + 1 : vs_in_run) : 0;
         vs_out_run <= vsync_o ? ((vs_out_run < 1000) ? vs_out_run + 1 : vs_out_run) : 0;
      end
   end

   assert_latch_point_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_chg_o |-> (hs_run == LATCH_AT + 1));

   assert_change_flagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      !$stable(mode_o) |-> mode_chg_o);

   assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_chg_o |=> !mode_chg_o);

   assert_div_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_div_o == ((mode_o == 2'd2) ? 3'd1 : (mode_o == 2'd1) ? 3'd2 : 3'd4));

   assert_vs_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_o |-> (vs_in_run >= VS_DELAY + 1));

   assert_vs_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vs_out_run <= VS_WIDTH);
endmodule

bind vidmode_sync_latch vml_checker #(
   .LATCH_AT(LATCH_AT), .VS_DELAY(VS_DELAY), .VS_WIDTH(VS_WIDTH)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
   .mode_o(mode_o), .pix_div_o(pix_div_o), .mode_chg_o(mode_chg_o),
   .vsync_o(vsync_o)
);

// File: tb/sim_vidmode_sync_latch.sv
`timescale 1ns/100ps
module sim_vidmode_sync_latch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b0, vsync = 1'b0, mode_wr = 1'b0;
   logic [1:0] mode_wdata = 2'd0;
   logic [1:0] mode_o;
   logic [2:0] pix_div_o;
   logic       mode_chg_o, vsync_o;

   int checks = 0, fails = 0;
   bit done = 0;
   int pulses = 0, vs_high = 0;

   always #2.5 clk = ~clk;

   vidmode_sync_latch u0 (
      .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
      .mode_o(mode_o), .pix_div_o(pix_div_o), .mode_chg_o(mode_chg_o),
      .vsync_o(vsync_o)
   );

   task automatic check(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
      end
   endtask

   // behavioural reference: run ages of sampled inputs
   int hs_age = 0, vs_age = 0, m_mode = 1, m_pend = 1, m_chg = 0, m_vs = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hs_age = 0; vs_age = 0; m_mode = 1; m_pend = 1; m_chg = 0; m_vs = 0;
      end else begin
         hs_age = hsync ? ((hs_age < 1000) ? hs_age + 1 : hs_age) : 0;
         vs_age = vsync ? ((vs_age < 1000) ? vs_age + 1 : vs_age) : 0;
         m_chg  = (hs_age == 5 && m_pend != m_mode) ? 1 : 0;
         if (m_chg != 0) m_mode = m_pend;
         if (mode_wr) m_pend = int'(mode_wdata);
         m_vs = (vs_age >= 3 && vs_age <= 6) ? 1 : 0;
      end
      #1;
      check(int'(mode_o), m_mode, "R2 mode_o");
      check(int'(pix_div_o), (m_mode == 2) ? 1 : (m_mode == 1) ? 2 : 4, "R6 pix_div_o");
      check(int'(mode_chg_o), m_chg, "R7 mode_chg_o");
      check(int'(vsync_o), m_vs, "R8 R9 vsync_o");
      if (mode_chg_o) pulses++;
      if (vsync_o) vs_high++;
   end

   task automatic cyc(input bit hs, input bit vs, input bit wr, input logic [1:0] wd);
      @(negedge clk);
      hsync = hs; vsync = vs; mode_wr = wr; mode_wdata = wd;
   endtask

   task automatic write_mode(input logic [1:0] wd);
      cyc(0, 0, 1, wd);
   endtask

   // hsync high for len edges, optional write at index wr_at, then low
   task automatic hline(input int len, input int wr_at, input logic [1:0] wd);
      for (int i = 0; i < len; i++) cyc(1, 0, i == wr_at, wd);
      cyc(0, 0, 0, 2'd0);
      cyc(0, 0, 0, 2'd0);
   endtask

   task automatic vpulse(input int len);
      for (int i = 0; i < len; i++) cyc(0, 1, 0, 2'd0);
      cyc(0, 0, 0, 2'd0);
      cyc(0, 0, 0, 2'd0);
   endtask

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      check(int'(mode_o), 1, "R1 reset mode");
      check(int'(pix_div_o), 2, "R1 reset divider");
      check(int'(mode_chg_o), 0, "R1 reset pulse");
      check(int'(vsync_o), 0, "R1 reset vsync");
      rst_n = 1'b1;
      cyc(0, 0, 0, 2'd0);
      // R1: pending is 1, so a line without a write changes nothing
      p0 = pulses; hline(8, -1, 2'd0);
      check(pulses - p0, 0, "R1 pending reset value");
      // R2, R7: mode 2 applied once
      write_mode(2'd2);
      p0 = pulses; hline(8, -1, 2'd0);
      check(int'(mode_o), 2, "R2 mode after line");
      check(int'(pix_div_o), 1, "R6 divider mode 2");
      check(pulses - p0, 1, "R7 one pulse");
      // R3: four high samples only
      write_mode(2'd0);
      p0 = pulses; hline(4, -1, 2'd0);
      check(int'(mode_o), 2, "R3 short line keeps mode");
      check(pulses - p0, 0, "R3 no pulse");
      hline(5, -1, 2'd0);
      check(int'(mode_o), 0, "R2 five samples apply");
      check(int'(pix_div_o), 4, "R6 divider mode 0");
      // R4: last write wins
      write_mode(2'd1); write_mode(2'd3);
      hline(6, -1, 2'd0);
      check(int'(mode_o), 3, "R4 last write wins");
      check(int'(pix_div_o), 4, "R6 divider code 3");
      // R5: equal pending, no pulse
      write_mode(2'd3);
      p0 = pulses; hline(7, -1, 2'd0);
      check(pulses - p0, 0, "R5 equal mode no pulse");
      // R4: write at latch edge goes to next line
      p0 = pulses; hline(8, 4, 2'd1);
      check(int'(mode_o), 3, "R4 write at latch edge deferred");
      hline(6, -1, 2'd0);
      check(int'(mode_o), 1, "R4 deferred write applied");
      check(pulses - p0, 1, "R4 one pulse total");
      // R10: write after latch edge in long hsync
      hline(20, 7, 2'd2);
      check(int'(mode_o), 1, "R10 late write not applied");
      hline(6, -1, 2'd0);
      check(int'(mode_o), 2, "R10 applied next line");
      // R8, R9: vsync shaping
      p0 = vs_high; vpulse(3);
      check(vs_high - p0, 1, "R9 short vsync truncated");
      p0 = vs_high; vpulse(12);
      check(vs_high - p0, 4, "R9 vsync capped");
      p0 = vs_high; vpulse(2);
      check(vs_high - p0, 0, "R8 two-sample vsync gives nothing");
      p0 = vs_high; vpulse(5);
      check(vs_high - p0, 3, "R8 delayed start");
      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule